// File: doc/BRIEF.md
# RTC Interrupt Status and Date-Alarm Register Block

This block keeps the interrupt side of a real-time clock together with its day-of-month alarm. A byte-wide register bus reaches it. The bus has an address, a read strobe, a write strobe, write data and registered read data. The timekeeping logic outside the block supplies three things: a level that is high while the time registers are being updated, a one-cycle pulse when an update finishes, and the current day of the month.

Each finished update raises an update flag. If a programmed day matches, it also raises an alarm flag. A read of the status register returns both flags and clears them. Each flag has its own enable. An enabled flag drives the combined request bit and pulls the active-low interrupt pin.

The alarm register carries a time-valid bit. A read of that register sets the bit, and a low-battery input clears it. The register also holds a 6-bit alarm day. The day is hidden when the alarm is switched off and hidden while an update is running. The synchronous reset leaves the stored day and the valid bit untouched.

Top module: `rtc_irq_alarm_regs`

## Requirements
- R1: The cycle after a pulse on `upd_done`, the update flag (status bit 3) is 1.
- R2: Status bit 7 and the interrupt pin follow the enabled flags. Status bit 7 is 1, and `irq_n` is 0, exactly when the update flag is set with the control register's bit 4 set, or the alarm flag is set with control bit 5 set. `irq_n` returns high right after the clock edge at which a status read clears the last enabled flag.
- R3: A status read (address 1) returns the flag values from before the read, then clears both flags at that edge. If a flag's set event comes in the same cycle as the read, the flag ends up set.
- R4: Status bits 6, 4 and 2:0 always read 0. Bus writes to address 1 change nothing.
- R5: Bit 7 of the alarm register (address 2) is the time-valid bit. Bus writes cannot change it. A read of address 2 returns its old value and sets it to 1.
- R6: While `batt_low` is 1, the valid bit is forced to 0. This takes priority over the read-sets rule.
- R7: Alarm bit 6 reads 0. Bits 5:0 store the alarm day written to address 2. They read back as 0 whenever the date-alarm enable (control bit 0) is 0.
- R8: Reset clears the control register, both flags and `bus_rdata`, and leaves `irq_n` high. It does not alter the stored alarm day or the valid bit.
- R9: While `upd_active` is 1, writes to address 2 are ignored and a read of address 2 returns 0 in bits 6:0.
- R10: On an `upd_done` pulse with the date alarm enabled, the alarm flag (status bit 5) is set if the stored day equals `cur_date`, or if stored bits 5:4 are both 1 (match any day).
- R11: The control register (address 0) stores bits 5, 4 and 0. Its other bits read 0.
- R12: `bus_rdata` changes only on the edge after a read strobe, and holds otherwise. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| upd_active | input | 1 | High while a time update is in progress |
| upd_done | input | 1 | One-cycle pulse at the end of an update |
| cur_date | input | 6 | Current day of month from the counters |
| batt_low | input | 1 | Low-battery indication |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong flag state shows on `irq_n` on the very next cycle, because the pin is formed straight from the flag and enable registers. The same error shows in the status byte on the first status read. A wrong valid bit or alarm day stays hidden until the alarm register is read, so the bench reads address 2 after every event that could disturb it: reset, low battery, updates and masked writes. A lost set-versus-clear race shows as a status byte of zero on the read that follows the collision.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  // register addresses
  localparam int ADR_CTRL  = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_ALARM = 2;
  // control bits
  localparam int CTRL_AEN_BIT = 0;
  localparam int CTRL_UIE_BIT = 4;
  localparam int CTRL_AIE_BIT = 5;
  // status bits
  localparam int STAT_UF_BIT  = 3;
  localparam int STAT_AF_BIT  = 5;
  localparam int STAT_IRQ_BIT = 7;
  // alarm register
  localparam int VALID_BIT = 7;
  // flag vector indices
  localparam int FLG_UPD   = 0;
  localparam int FLG_ALM   = 1;
  localparam int NUM_FLAGS = 2;

  typedef struct packed {
    logic rd_ctrl;
    logic rd_stat;
    logic rd_alarm;
    logic wr_ctrl;
    logic wr_alarm;
  } bus_sel_t;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] WR_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= wdata & WR_MASK;
    end
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] set_i,
  input  logic           clr_i,
  input  logic [NUM-1:0] en_i,
  output logic [NUM-1:0] flag_q,
  output logic           irq_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[g] <= 1'b0;
      end else if (set_i[g]) begin
        flag_q[g] <= 1'b1;
      end else if (clr_i) begin
        flag_q[g] <= 1'b0;
      end
    end
  end

  assign irq_o = |(flag_q & en_i);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int DATE_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [DATE_W-1:0] wdata,
  input  logic              rd_mark,
  input  logic              batt_low,
  input  logic [DATE_W-1:0] cur_date,
  output logic [DATE_W-1:0] alarm_q,
  output logic              valid_q,
  output logic              hit_o
);
  localparam int DC_HI = DATE_W - 1;
  localparam int DC_LO = DATE_W - 2;

  logic any_day;

  // stored day survives reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      alarm_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (batt_low) begin
      valid_q <= 1'b0;
    end else if (rd_mark) begin
      valid_q <= 1'b1;
    end
  end

  assign any_day = alarm_q[DC_HI] & alarm_q[DC_LO];
  assign hit_o   = any_day | (alarm_q == cur_date);
endmodule

// File: rtl/rtc_irq_alarm_regs.sv
module rtc_irq_alarm_regs #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int DATE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              upd_active,
  input  logic              upd_done,
  input  logic [DATE_W-1:0] cur_date,
  input  logic              batt_low,
  output logic              irq_n
);
  import rtc_regs_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(ADR_ALARM);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << CTRL_AEN_BIT) | (DATA_W'(1) << CTRL_UIE_BIT) |
    (DATA_W'(1) << CTRL_AIE_BIT);

  bus_sel_t              sel;
  logic [DATA_W-1:0]     ctrl_q;
  logic [NUM_FLAGS-1:0]  flag_q;
  logic [NUM_FLAGS-1:0]  flag_set;
  logic [NUM_FLAGS-1:0]  irq_en;
  logic                  irq;
  logic [DATE_W-1:0]     alarm_q;
  logic                  valid_q;
  logic                  hit;
  logic                  alarm_en;
  logic [DATA_W-1:0]     stat_word;
  logic [DATA_W-1:0]     alarm_word;
  logic [DATA_W-1:0]     rd_word;

  // address decode
  always_comb begin
    sel.rd_ctrl  = bus_rd && (bus_addr == A_CTRL);
    sel.rd_stat  = bus_rd && (bus_addr == A_STAT);
    sel.rd_alarm = bus_rd && (bus_addr == A_ALARM);
    sel.wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    sel.wr_alarm = bus_wr && (bus_addr == A_ALARM) && !upd_active;
  end

  rtc_ctrl_reg #(
    .DATA_W (DATA_W),
    .WR_MASK(CTRL_MASK)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (sel.wr_ctrl),
    .wdata (bus_wdata),
    .ctrl_q(ctrl_q)
  );

  assign alarm_en = ctrl_q[CTRL_AEN_BIT];

  rtc_alarm_unit #(
    .DATE_W(DATE_W)
  ) alarm_i (
    .clk     (clk),
    .wr_en   (sel.wr_alarm),
    .wdata   (bus_wdata[DATE_W-1:0]),
    .rd_mark (sel.rd_alarm),
    .batt_low(batt_low),
    .cur_date(cur_date),
    .alarm_q (alarm_q),
    .valid_q (valid_q),
    .hit_o   (hit)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_UPD] = upd_done;
    flag_set[FLG_ALM] = upd_done && alarm_en && hit;
    irq_en            = '0;
    irq_en[FLG_UPD]   = ctrl_q[CTRL_UIE_BIT];
    irq_en[FLG_ALM]   = ctrl_q[CTRL_AIE_BIT];
  end

  rtc_flag_unit #(
    .NUM(NUM_FLAGS)
  ) flags_i (
    .clk   (clk),
    .rst   (rst),
    .set_i (flag_set),
    .clr_i (sel.rd_stat),
    .en_i  (irq_en),
    .flag_q(flag_q),
    .irq_o (irq)
  );

  assign irq_n = ~irq;

  // read words
  always_comb begin
    stat_word               = '0;
    stat_word[STAT_UF_BIT]  = flag_q[FLG_UPD];
    stat_word[STAT_AF_BIT]  = flag_q[FLG_ALM];
    stat_word[STAT_IRQ_BIT] = irq;

    alarm_word = '0;
    if (!upd_active && alarm_en) begin
      alarm_word[DATE_W-1:0] = alarm_q;
    end
    alarm_word[VALID_BIT] = valid_q;
  end

  always_comb begin
    rd_word = '0;
    if (sel.rd_ctrl)  rd_word = ctrl_q;
    if (sel.rd_stat)  rd_word = stat_word;
    if (sel.rd_alarm) rd_word = alarm_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/rtc_irq_alarm_chk.sv
module rtc_irq_alarm_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int NUM    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              upd_active,
  input logic              upd_done,
  input logic              batt_low,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_n,
  input logic [NUM-1:0]    flags,
  input logic [NUM-1:0]    irq_en,
  input logic              valid
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(rtc_regs_pkg::ADR_STAT);
  localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(rtc_regs_pkg::ADR_ALARM);

  p_upd_set_r1: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> flags[0]);

  p_irq_low_r2: assert property (@(posedge clk) disable iff (rst)
    (|(flags & irq_en)) |-> !irq_n);

  p_irq_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |-> irq_n);

  p_rd_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT && !upd_done) |=> (flags == '0));

  p_stat_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=>
      (bus_rdata[6] == 1'b0 && bus_rdata[4] == 1'b0 && bus_rdata[2:0] == 3'b0));

  p_stat_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STAT && !bus_rd && !upd_done) |=> $stable(flags));

  p_valid_set_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_ALARM && !batt_low) |=> valid);

  p_batt_r6: assert property (@(posedge clk) disable iff (rst)
    batt_low |=> !valid);

  p_upd_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_ALARM && upd_active) |=> (bus_rdata[6:0] == 7'b0));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind rtc_irq_alarm_regs rtc_irq_alarm_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .NUM   (rtc_regs_pkg::NUM_FLAGS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .upd_active(upd_active),
  .upd_done  (upd_done),
  .batt_low  (batt_low),
  .bus_rdata (bus_rdata),
  .irq_n     (irq_n),
  .flags     (flag_q),
  .irq_en    (irq_en),
  .valid     (valid_q)
);

// File: tb/rtc_irq_alarm_regs_tb.sv
module rtc_irq_alarm_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       upd_act = 1'b0;
  logic       upd_done = 1'b0;
  logic [5:0] date = '0;
  logic       batt = 1'b1;
  logic       irq_n;

  int    checks = 0;
  int    errors = 0;
  bit    running = 1'b0;
  string phase = "R8";

  // reference state
  logic [7:0] m_ctrl = '0;
  logic       m_uf = 1'b0;
  logic       m_af = 1'b0;
  logic [7:0] m_rdata = '0;
  logic       m_valid = 1'b0;
  logic [5:0] m_alarm = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_alarm_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .upd_active(upd_act),
    .upd_done(upd_done), .cur_date(date), .batt_low(batt), .irq_n(irq_n)
  );

  function automatic logic m_irq();
    return (m_uf && m_ctrl[4]) || (m_af && m_ctrl[5]);
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    logic [7:0] n_ctrl, n_rdata, word;
    logic       n_uf, n_af, n_valid, match;
    logic [5:0] n_alarm;
    n_ctrl = m_ctrl; n_uf = m_uf; n_af = m_af; n_rdata = m_rdata;
    n_valid = m_valid; n_alarm = m_alarm;
    match = (m_alarm[5:4] == 2'b11) || (m_alarm == date);
    word = 8'h00;
    case (addr)
      2'd0: word = m_ctrl;
      2'd1: word = {m_irq(), 1'b0, m_af, 1'b0, m_uf, 3'b000};
      2'd2: word = {m_valid, (upd_act || !m_ctrl[0]) ? 7'h00 : {1'b0, m_alarm}};
      default: word = 8'h00;
    endcase
    if (batt) n_valid = 1'b0;
    else if (rd && addr == 2'd2) n_valid = 1'b1;
    if (wr && addr == 2'd2 && !upd_act) n_alarm = wdata[5:0];
    if (rst) begin
      n_ctrl = 8'h00; n_uf = 1'b0; n_af = 1'b0; n_rdata = 8'h00;
    end else begin
      if (rd) n_rdata = word;
      if (wr && addr == 2'd0) n_ctrl = wdata & 8'h31;
      if (rd && addr == 2'd1) begin n_uf = 1'b0; n_af = 1'b0; end
      if (upd_done) n_uf = 1'b1;
      if (upd_done && m_ctrl[0] && match) n_af = 1'b1;
    end
    m_ctrl = n_ctrl; m_uf = n_uf; m_af = n_af; m_rdata = n_rdata;
    m_valid = n_valid; m_alarm = n_alarm;
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s bus_rdata actual %h expected %h at %0t", phase, rdata, m_rdata, $time);
      end
      checks++;
      if (irq_n !== !m_irq()) begin
        errors++;
        $display("FAIL %s irq_n actual %b expected %b at %0t", phase, irq_n, !m_irq(), $time);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_reg(logic [1:0] a);
    addr = a; rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_done();
    upd_done = 1'b1; @(negedge clk); upd_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    @(negedge clk);
    running = 1'b1;
    phase = "R8";
    idle(3);
    rst = 1'b0; batt = 1'b0;
    idle(1);

    phase = "R5";                 // valid bit returned old, then set
    rd_reg(2'd2);
    rd_reg(2'd2);
    wr_reg(2'd2, 8'h00);          // write cannot clear valid
    rd_reg(2'd2);

    phase = "R11";
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0);

    phase = "R7";
    wr_reg(2'd2, 8'h0F);
    rd_reg(2'd2);
    wr_reg(2'd2, 8'hFF);          // bit 6 stays 0
    rd_reg(2'd2);
    wr_reg(2'd0, 8'h00);          // disabled: day hidden
    rd_reg(2'd2);

    phase = "R9";
    upd_act = 1'b1;
    wr_reg(2'd2, 8'h05);
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd2);
    upd_act = 1'b0;
    rd_reg(2'd2);                 // still previous day

    phase = "R1";
    wr_reg(2'd0, 8'h00);
    pulse_done();
    rd_reg(2'd1);
    phase = "R3";
    rd_reg(2'd1);

    phase = "R2";
    wr_reg(2'd0, 8'h10);
    pulse_done();
    idle(2);
    rd_reg(2'd1);
    idle(1);

    phase = "R3";                 // set and read in one cycle
    upd_done = 1'b1; addr = 2'd1; rd = 1'b1;
    @(negedge clk);
    upd_done = 1'b0; rd = 1'b0;
    rd_reg(2'd1);
    rd_reg(2'd1);

    phase = "R4";
    pulse_done();
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1);

    phase = "R10";
    wr_reg(2'd0, 8'h21);
    wr_reg(2'd2, 8'h0F);
    date = 6'h0E;
    pulse_done();
    rd_reg(2'd1);
    date = 6'h0F;
    pulse_done();
    idle(1);
    rd_reg(2'd1);
    wr_reg(2'd2, 8'h30);          // any-day code
    date = 6'h07;
    pulse_done();
    rd_reg(2'd1);
    wr_reg(2'd2, 8'h31);
    date = 6'h1A;
    pulse_done();
    rd_reg(2'd1);

    phase = "R6";
    batt = 1'b1;
    rd_reg(2'd2);
    rd_reg(2'd2);
    batt = 1'b0;
    rd_reg(2'd2);
    rd_reg(2'd2);

    phase = "R8";
    wr_reg(2'd2, 8'h2A);
    wr_reg(2'd0, 8'h31);
    pulse_done();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd_reg(2'd0);
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd2);

    phase = "R12";
    rd_reg(2'd3);
    idle(3);
    wr_reg(2'd0, 8'h11);
    idle(2);

    running = 1'b0;
    finish_run();
  end
endmodule